// File: doc/BRIEF.md
# LVDS Lane Serializer with Forwarded Clock

This block turns one parallel word per lane and per pixel period into a serial bit stream on each LVDS data lane, and serializes a matching clock lane from a fixed bit pattern. It runs entirely from the fast bit clock. The pixel clock is produced inside the block by dividing the bit clock by the gear, which is the number of bits each lane carries per pixel period: 7 or 14. The logic that produces the lane words is expected to run from that divided clock.

An asynchronous, active-low reset first passes through a two-stage synchronizer. A fixed wait of 16 bit clocks follows, and only then is the `ready` output raised. Until `ready` is high, every serial output and the pixel clock hold zero, so no high-speed traffic can leave the block before the sequence has finished. The gear input is captured only while `ready` is low. A change to the gear takes effect after the next reset.

Top module: `lvds_serializer_top`

## Requirements
- R1: While `rst_n` is low, `ready`, `pix_clk`, `ser_clk` and every bit of `ser_data` are 0.
- R2: `ready` rises on exactly the 18th rising edge of `clk_bit` after `rst_n` goes high (two synchronizer stages, then 16 wait cycles), and stays high until the next reset.
- R3: While `ready` is low, `ser_data`, `ser_clk` and `pix_clk` are all 0.
- R4: Lane i takes its word from `lane_data[14*i+13:14*i]`. With `gear_sel`=0 (gear 7), only bits [6:0] of that slice are sent, bit 6 first, and bits [13:7] have no effect. With `gear_sel`=1 (gear 14), bits [13:0] are sent, bit 13 first.
- R5: A word is sampled on the bit-clock edge where `pix_clk` rises. The first such edge is the first one after `ready` rises, and the next comes every G edges after that (G = 7 or 14). The word's first bit is on the lane right after the sampling edge, and each later edge shifts out the next bit.
- R6: In gear 7 the clock lane repeats 1100011, leftmost bit first, aligned with the data words.
- R7: In gear 14 the clock lane repeats 11000111100011, leftmost bit first, aligned with the data words.
- R8: While `ready` is high, `pix_clk` has a period of G bit clocks. It is high for the first 4 (gear 7) or 7 (gear 14) bit clocks of each word and low for the rest.
- R9: `gear_sel` is captured only while `ready` is low. Changing it while `ready` is high does not change the serial output.
- R10: Pulling `rst_n` low forces all outputs to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gear_sel | input | 1 | 0 selects 7 bits per lane, 1 selects 14 |
| lane_data | input | 14*NUM_LANES | Parallel lane words, 14 bits per lane slice |
| ser_data | output | NUM_LANES | Serial data lanes |
| ser_clk | output | 1 | Serial forwarded clock lane |
| pix_clk | output | 1 | Bit clock divided by the gear |
| ready | output | 1 | Reset sequence complete; transmission allowed |

## Verification
The assertions assume that `lane_data` is stable at each edge where `pix_clk` rises. This matters because the check on each word's first bit compares against the lane slice captured one edge earlier. They also assume that `gear_sel` only matters during reset, since they check that the captured gear holds while `ready` is high.

The bench changes `lane_data` only on the falling edge just after `pix_clk` rises, which leaves a full word period before the next sampling edge. It switches `gear_sel` in the middle of a stream on purpose, to show that this has no effect. For gear 7 it also fills the unused upper bits of each slice with varying junk.

// File: rtl/lvds_ser_pkg.sv
// Shared constants and helpers for the LVDS lane serializer.
// Assumes the widest gear is 14 bits and the narrow gear is 7 bits.
package lvds_ser_pkg;

    localparam int MAX_GEAR = 14;
    localparam int MIN_GEAR = 7;
    localparam int IDX_W    = $clog2(MAX_GEAR);

    localparam logic [MAX_GEAR-1:0] CLK_PAT_WIDE   = 14'b11000111100011;
    localparam logic [MIN_GEAR-1:0] CLK_PAT_NARROW = 7'b1100011;

    typedef enum logic {
        GEAR_7  = 1'b0,
        GEAR_14 = 1'b1
    } gear_e;

    // Number of bits per lane per pixel period for a gear.
    function automatic int gear_bits(gear_e g);
        return (g == GEAR_14) ? MAX_GEAR : MIN_GEAR;
    endfunction

    // Number of bit clocks the pixel clock stays high (rounded up half).
    function automatic int gear_high(gear_e g);
        return (gear_bits(g) + 1) / 2;
    endfunction

endpackage

// File: rtl/lvds_rst_seq.sv
// Reset sequencer: synchronizes the release of an asynchronous active-low
// reset with two flops, then waits WAIT_CYCLES bit clocks before raising
// ready. Assertion of rst_n propagates to every output at once.
// Assumes rst_n may change at any time relative to clk.
module lvds_rst_seq #(
    parameter int WAIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic srst_n,
    output logic ready
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);

    logic           sync_a_q;
    logic           sync_b_q;
    logic [CW-1:0]  wait_q;
    logic           ready_q;

    // Two-stage release synchronizer with asynchronous assertion.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a_q <= 1'b0;
            sync_b_q <= 1'b0;
        end else begin
            sync_a_q <= 1'b1;
            sync_b_q <= sync_a_q;
        end
    end

    // Wait counter that raises ready after the fixed settling window.
    always_ff @(posedge clk or negedge sync_b_q) begin
        if (!sync_b_q) begin
            wait_q  <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            if (wait_q == CW'(WAIT_CYCLES - 1)) begin
                ready_q <= 1'b1;
            end
            wait_q <= wait_q + 1'b1;
        end
    end

    assign srst_n = sync_b_q;
    assign ready  = ready_q;

endmodule

// File: rtl/lvds_frame_ctrl.sv
// Word framing: latches the gear while not ready, keeps the bit index
// within a word, issues the load strobe and produces the divided pixel
// clock. Assumes ready is low whenever srst_n is low.
module lvds_frame_ctrl
    import lvds_ser_pkg::*;
(
    input  logic  clk,
    input  logic  srst_n,
    input  logic  ready,
    input  logic  gear_sel,
    output gear_e gear_q,
    output logic  load,
    output logic  pix_clk
);
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] high_len;
    logic [IDX_W-1:0] idx_inc;
    logic             pix_q;

    assign last_idx = IDX_W'(gear_bits(gear_q) - 1);
    assign high_len = IDX_W'(gear_high(gear_q));
    assign idx_inc  = idx_q + 1'b1;
    assign load     = ready && (idx_q >= last_idx);

    // Capture the gear only during the reset sequence.
    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
            gear_q <= GEAR_7;
        end else if (!ready) begin
            gear_q <= gear_e'(gear_sel);
        end
    end

    // Bit index within the current word; parked at the top so the first
    // ready cycle loads a word.
    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
            idx_q <= IDX_W'(MAX_GEAR - 1);
        end else if (!ready) begin
            idx_q <= IDX_W'(MAX_GEAR - 1);
        end else if (load) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_inc;
        end
    end

    // Registered divided clock, high for the first half of each word.
    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
            pix_q <= 1'b0;
        end else if (!ready) begin
            pix_q <= 1'b0;
        end else if (load) begin
            pix_q <= 1'b1;
        end else begin
            pix_q <= (idx_inc < high_len);
        end
    end

    assign pix_clk = pix_q;

endmodule

// File: rtl/lvds_lane_shift.sv
// One serial lane: loads an MSB-aligned word on the load strobe and shifts
// it out most significant bit first, filling with zeros.
// Assumes the word is already aligned to the top of the register.
module lvds_lane_shift #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] word,
    output logic             ser
);
    logic [WIDTH-1:0] sh_q;

    // Parallel load or left shift of the lane register.
    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= word;
        end else begin
            sh_q <= {sh_q[WIDTH-2:0], 1'b0};
        end
    end

    assign ser = sh_q[WIDTH-1];

endmodule

// File: rtl/lvds_serializer_top.sv
// LVDS lane serializer top: reset sequencing, word framing, one shift lane
// per data lane and one for the forwarded clock pattern.
// Assumes lane_data is stable at each edge where pix_clk rises.
module lvds_serializer_top
    import lvds_ser_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int WAIT_CYCLES = 16
) (
    input  logic                          clk_bit,
    input  logic                          rst_n,
    input  logic                          gear_sel,
    input  logic [NUM_LANES*MAX_GEAR-1:0] lane_data,
    output logic [NUM_LANES-1:0]          ser_data,
    output logic                          ser_clk,
    output logic                          pix_clk,
    output logic                          ready
);
    localparam int PAD = MAX_GEAR - MIN_GEAR;

    logic               srst_n;
    logic               ready_i;
    logic               load;
    gear_e              gear_q;
    logic [MAX_GEAR-1:0] clk_word;

    lvds_rst_seq #(
        .WAIT_CYCLES(WAIT_CYCLES)
    ) i_rst_seq (
        .clk   (clk_bit),
        .rst_n (rst_n),
        .srst_n(srst_n),
        .ready (ready_i)
    );

    lvds_frame_ctrl i_frame (
        .clk     (clk_bit),
        .srst_n  (srst_n),
        .ready   (ready_i),
        .gear_sel(gear_sel),
        .gear_q  (gear_q),
        .load    (load),
        .pix_clk (pix_clk)
    );

    // Clock lane pattern aligned to the top of the shift register.
    always_comb begin
        if (gear_q == GEAR_14) begin
            clk_word = CLK_PAT_WIDE;
        end else begin
            clk_word = {CLK_PAT_NARROW, {PAD{1'b0}}};
        end
    end

    lvds_lane_shift #(
        .WIDTH(MAX_GEAR)
    ) i_clk_lane (
        .clk   (clk_bit),
        .srst_n(srst_n),
        .load  (load),
        .word  (clk_word),
        .ser   (ser_clk)
    );

    for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
        logic [MAX_GEAR-1:0] slice;
        logic [MAX_GEAR-1:0] aligned;

        assign slice = lane_data[gi*MAX_GEAR +: MAX_GEAR];

        // Align the used bits of the slice to the shift register top.
        always_comb begin
            if (gear_q == GEAR_14) begin
                aligned = slice;
            end else begin
                aligned = {slice[MIN_GEAR-1:0], {PAD{1'b0}}};
            end
        end

        lvds_lane_shift #(
            .WIDTH(MAX_GEAR)
        ) i_lane (
            .clk   (clk_bit),
            .srst_n(srst_n),
            .load  (load),
            .word  (aligned),
            .ser   (ser_data[gi])
        );
    end

    assign ready = ready_i;

endmodule

// File: rtl/lvds_serializer_chk.sv
// Property checker for the LVDS lane serializer, bound to the top module.
// Assumes lane_data is stable at each edge where pix_clk rises.
module lvds_serializer_chk
    import lvds_ser_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input logic                          clk_bit,
    input logic                          rst_n,
    input logic [NUM_LANES*MAX_GEAR-1:0] lane_data,
    input logic [NUM_LANES-1:0]          ser_data,
    input logic                          ser_clk,
    input logic                          pix_clk,
    input logic                          ready,
    input logic                          gear_q
);
    logic [NUM_LANES-1:0] first_bits;

    for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_first
        assign first_bits[gi] = gear_q ? lane_data[gi*MAX_GEAR + MAX_GEAR - 1]
                                       : lane_data[gi*MAX_GEAR + MIN_GEAR - 1];
    end

    // R3
    quiet_until_ready_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !ready |-> (ser_data == '0 && !ser_clk && !pix_clk));

    // R2
    ready_holds_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        ready |=> ready);

    // R9
    gear_frozen_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        ready |=> $stable(gear_q));

    // R5
    first_bit_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(pix_clk) |-> (ser_data == $past(first_bits)));

    // R6
    clk_lane_start_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(pix_clk) |-> ser_clk);

    // R8
    pix_needs_ready_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
        pix_clk |-> ready);

endmodule

bind lvds_serializer_top lvds_serializer_chk #(
    .NUM_LANES(NUM_LANES)
) i_chk (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .lane_data(lane_data),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .pix_clk  (pix_clk),
    .ready    (ready),
    .gear_q   (gear_q)
);

// File: tb/test_lvds_serializer_top.sv
// Self-checking bench: sweeps word streams in both gears and checks every
// serial bit, the clock lane, the pixel clock and the reset sequence.
module test_lvds_serializer_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int W          = 14;

    logic               clk_bit = 1'b0;
    logic               rst_n   = 1'b0;
    logic               gear_sel = 1'b0;
    logic [LANES*W-1:0] lane_data = '0;
    logic [LANES-1:0]   ser_data;
    logic               ser_clk;
    logic               pix_clk;
    logic               ready;

    int n_checks = 0;
    int n_fail   = 0;

    lvds_serializer_top #(
        .NUM_LANES(LANES),
        .WAIT_CYCLES(16)
    ) i_lvds_serializer_top (
        .clk_bit  (clk_bit),
        .rst_n    (rst_n),
        .gear_sel (gear_sel),
        .lane_data(lane_data),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .pix_clk  (pix_clk),
        .ready    (ready)
    );

    always #(CLK_PERIOD/2) clk_bit = ~clk_bit;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Used bits of the word for stream position w on lane i.
    function automatic logic [13:0] word_of(int w, int i, int g);
        int v;
        v = w * (2*i + 3) + i * 91 + (w >> 3) * 17;
        return (g != 0) ? 14'(v) : 14'(v & 7'h7f);
    endfunction

    // Full 14-bit slice; in gear 7 the unused top bits carry junk (R4).
    function automatic logic [LANES*W-1:0] bus_of(int w, int g);
        logic [LANES*W-1:0] b;
        for (int i = 0; i < LANES; i++) begin
            logic [13:0] s;
            s = word_of(w, i, g);
            if (g == 0) s[13:7] = 7'(w * 5 + i + 1);
            b[i*W +: W] = s;
        end
        return b;
    endfunction

    task automatic check_quiet(input string req);
        check(ser_data == '0, req, int'(ser_data), 0);
        check(!ser_clk && !pix_clk, req, int'({ser_clk, pix_clk}), 0);
    endtask

    task automatic run_gear(input int g, input int nwords);
        int gb;
        int half;
        logic [13:0] pat;
        gb   = (g != 0) ? 14 : 7;
        half = (gb + 1) / 2;
        pat  = (g != 0) ? 14'b11000111100011 : 14'(7'b1100011);
        @(negedge clk_bit);
        rst_n     = 1'b0;
        gear_sel  = 1'(g);
        lane_data = bus_of(0, g);
        repeat (3) @(negedge clk_bit);
        // R1: reset state
        check(!ready, "R1", int'(ready), 0);
        check_quiet("R1");
        rst_n = 1'b1;
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk_bit);
            // R2: ready exactly after 18 edges
            check(ready == (k == 18), "R2", int'(ready), int'(k == 18));
            // R3: lanes quiet until the first load
            check_quiet("R3");
        end
        for (int pos = 0; pos < nwords * gb; pos++) begin
            int w;
            int b;
            logic [LANES-1:0] exp_d;
            @(negedge clk_bit);
            w = pos / gb;
            b = gb - 1 - (pos % gb);
            for (int i = 0; i < LANES; i++) begin
                logic [13:0] ww;
                ww = word_of(w, i, g);
                exp_d[i] = ww[b];
            end
            // R4 R5 R9: data bits, MSB first, gear frozen
            check(ser_data == exp_d, (g != 0) ? "R4_R5_R9 gear14" : "R4_R5_R9 gear7",
                  int'(ser_data), int'(exp_d));
            // R6 R7: clock lane pattern
            check(ser_clk == pat[b], (g != 0) ? "R7" : "R6", int'(ser_clk), int'(pat[b]));
            // R8: pixel clock shape
            check(pix_clk == ((pos % gb) < half), "R8", int'(pix_clk),
                  int'((pos % gb) < half));
            if ((pos % gb) == 0) lane_data = bus_of(w + 1, g);
            if (pos == gb * 5 + 2) gear_sel = 1'(g == 0);
        end
        // R10: asynchronous reset clears outputs immediately
        @(negedge clk_bit);
        #1;
        rst_n = 1'b0;
        #1;
        check(!ready, "R10", int'(ready), 0);
        check_quiet("R10");
    endtask

    initial begin
        run_gear(0, 130);
        run_gear(1, 150);
        run_gear(0, 20);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule